// File: doc/BRIEF.md
# Clock Lock Health Supervisor

This block watches a clock-management unit from a separate, free-running supervisor clock and turns its status into one dependable "clock healthy" flag. A raw lock flag can fall for a short time and then recover. It can also stay high after a clock has died. For these reasons the supervisor does not simply pass the flag through. It synchronizes the flag and remembers any loss of lock until reset. It also runs two activity watchdogs, one on the reference clock and one on the synthesized clock.

A second output holds a downstream, cascaded clock unit in reset. That reset is released only after the healthy flag has stayed high for a fixed number of supervisor cycles. The clock-management unit is not part of this block.

Top module: `clk_health_sup`

## Requirements
- R1: `lock_ok` goes high two supervisor edges after the edge that first samples `raw_lock` high following reset.
- R2: Once `lock_ok` has been high, a `raw_lock` low level held across even one supervisor edge clears `lock_ok`. `lock_ok` then stays low until reset, even if `raw_lock` returns high.
- R3: `ref_stopped` stays low while rising edges of `ref_clk` come at most `STALL_CYCLES` supervisor cycles apart. A gap of `STALL_CYCLES`+1 cycles or more sets it.
- R4: `syn_stopped` follows the same rule as R3 for `syn_clk`, independently of the reference clock.
- R5: `ref_stopped` and `syn_stopped` stay high after their clock resumes, until reset.
- R6: `healthy` is high only when `lock_ok` is high and neither stopped bit is set. A high `raw_lock` does not keep it high while a clock is stopped.
- R7: `cascade_rst` (active high) goes low after `healthy` has been high for `RELEASE_DLY` consecutive supervisor edges.
- R8: Whenever `healthy` is low, `cascade_rst` is high on the next cycle, and the release count starts again from zero.
- R9: Synchronous active-high `sup_rst` clears `lock_ok` and both stopped bits, forces `healthy` low and holds `cascade_rst` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sup_clk | input | 1 | Free-running supervisor clock |
| sup_rst | input | 1 | Synchronous active-high reset |
| raw_lock | input | 1 | Unsynchronized lock flag from the clock unit |
| ref_clk | input | 1 | Reference clock being watched |
| syn_clk | input | 1 | Synthesized output clock being watched |
| lock_ok | output | 1 | Lock seen and never lost since reset |
| ref_stopped | output | 1 | Sticky: reference clock activity lost |
| syn_stopped | output | 1 | Sticky: synthesized clock activity lost |
| healthy | output | 1 | Overall healthy indication |
| cascade_rst | output | 1 | Reset for a cascaded second clock unit |

## Verification
The bench builds the block with `STALL_CYCLES` = 10 and `RELEASE_DLY` = 5. With these values, reference-clock edge gaps of exactly 10 and exactly 11 supervisor cycles fit into a short run, so both sides of the stall boundary are tested. The full cascade release can also be watched several times, once after each reset. Both watched clocks are generated from supervisor clock edges. The cycle in which each stopped bit sets is therefore known exactly and is compared on every edge.

// File: rtl/clk_health_sup.sv
module clk_health_sup #(
  parameter int STALL_CYCLES = 64,
  parameter int RELEASE_DLY  = 16
) (
  input  logic sup_clk,
  input  logic sup_rst,
  input  logic raw_lock,
  input  logic ref_clk,
  input  logic syn_clk,
  output logic lock_ok,
  output logic ref_stopped,
  output logic syn_stopped,
  output logic healthy,
  output logic cascade_rst
);
  localparam int CW = $clog2(STALL_CYCLES + 1);
  localparam logic [CW-1:0] STALL_LIM = CW'(STALL_CYCLES);

  logic [1:0] lk_sync;
  logic       got_q;
  logic       lost_q;

  always_ff @(posedge sup_clk) begin
    if (sup_rst) begin
      lk_sync <= '0;
      got_q   <= 1'b0;
      lost_q  <= 1'b0;
    end else begin
      lk_sync <= {lk_sync[0], raw_lock};
      got_q   <= got_q | lk_sync[1];
      lost_q  <= lost_q | (got_q & ~lk_sync[1]);
    end
  end

  assign lock_ok = got_q & ~lost_q;

  logic [1:0] wclk;
  logic [1:0] stop_v;
  assign wclk = {syn_clk, ref_clk};

  for (genvar g = 0; g < 2; g++) begin : g_watch
    logic          tgl;
    logic [2:0]    ws;
    logic [CW-1:0] idle;
    logic          stop_q;

    always_ff @(posedge wclk[g]) begin
      if (sup_rst) tgl <= 1'b0;
      else         tgl <= ~tgl;
    end

    always_ff @(posedge sup_clk) begin
      if (sup_rst) begin
        ws     <= '0;
        idle   <= '0;
        stop_q <= 1'b0;
      end else begin
        ws     <= {ws[1:0], tgl};
        stop_q <= stop_q | (idle == STALL_LIM);
        if (ws[2] ^ ws[1])          idle <= '0;
        else if (idle != STALL_LIM) idle <= idle + 1'b1;
      end
    end

    assign stop_v[g] = stop_q;
  end

  assign ref_stopped = stop_v[0];
  assign syn_stopped = stop_v[1];
  assign healthy     = lock_ok & ~ref_stopped & ~syn_stopped;

  logic [RELEASE_DLY-1:0] rel_sr;

  always_ff @(posedge sup_clk) begin
    if (sup_rst || !healthy) rel_sr <= '0;
    else                     rel_sr <= (rel_sr << 1) | RELEASE_DLY'(1);
  end

  assign cascade_rst = ~rel_sr[RELEASE_DLY-1];
endmodule

// File: rtl/clk_health_sup_chk.sv
module clk_health_sup_chk (
  input logic sup_clk,
  input logic sup_rst,
  input logic lock_ok,
  input logic lost_q,
  input logic ref_stopped,
  input logic syn_stopped,
  input logic healthy,
  input logic cascade_rst
);
  // R2
  lock_no_return_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    $fell(lock_ok) |=> !lock_ok);
  // R2
  lost_hold_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    lost_q |=> (lost_q && !lock_ok));
  // R5
  ref_hold_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    ref_stopped |=> ref_stopped);
  // R5
  syn_hold_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    syn_stopped |=> syn_stopped);
  // R6
  stop_blocks_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    (ref_stopped || syn_stopped) |-> !healthy);
  // R7
  release_hist_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    !cascade_rst |-> $past(healthy));
  // R8
  drop_rearm_chk: assert property (@(posedge sup_clk) disable iff (sup_rst)
    !healthy |=> cascade_rst);
  // R9
  reset_clear_chk: assert property (@(posedge sup_clk)
    sup_rst |=> (!healthy && cascade_rst && !ref_stopped && !syn_stopped && !lock_ok));
endmodule

bind clk_health_sup clk_health_sup_chk u_chk (
  .sup_clk(sup_clk),
  .sup_rst(sup_rst),
  .lock_ok(lock_ok),
  .lost_q(lost_q),
  .ref_stopped(ref_stopped),
  .syn_stopped(syn_stopped),
  .healthy(healthy),
  .cascade_rst(cascade_rst)
);

// File: tb/sim_clk_health_sup.sv
`timescale 1ns/1ps
module sim_clk_health_sup;
  localparam int ST = 10;
  localparam int RD = 5;

  logic clk = 1'b0, rst = 1'b1, raw = 1'b0, rclk = 1'b0, sclk = 1'b0;
  logic lock_ok, ref_stopped, syn_stopped, healthy, cascade_rst;

  clk_health_sup #(.STALL_CYCLES(ST), .RELEASE_DLY(RD)) u0 (
    .sup_clk(clk), .sup_rst(rst), .raw_lock(raw), .ref_clk(rclk), .syn_clk(sclk),
    .lock_ok(lock_ok), .ref_stopped(ref_stopped), .syn_stopped(syn_stopped),
    .healthy(healthy), .cascade_rst(cascade_rst));

  always #2.5 clk = ~clk;

  int compared = 0, mismatched = 0, cycles = 0;
  bit done = 0;

  task automatic cmp(string req, string nm, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // watched clock generators, stepped on supervisor falling edges
  bit ren = 1, sen = 1, rseen = 0, sseen = 0;
  int rhi = 2, rlo = 2, shi = 1, slo = 1, rcnt = 0, scnt = 0;
  always @(negedge clk) begin
    if (ren) begin
      rcnt++;
      if (rclk && rcnt >= rhi) begin rclk = 0; rcnt = 0; end
      else if (!rclk && rcnt >= rlo) begin rclk = 1; rcnt = 0; if (!rst) rseen = 1; end
    end
    if (sen) begin
      scnt++;
      if (sclk && scnt >= shi) begin sclk = 0; scnt = 0; end
      else if (!sclk && scnt >= slo) begin sclk = 1; scnt = 0; if (!sseen && !rst) sseen = 1; end
    end
  end

  // reference model
  bit m_l1, m_l2, m_got, m_lost, m_rs, m_ss, r_q1, r_q2, s_q1, s_q2, h_old;
  int r_idle, s_idle, hc;
  always begin
    @(posedge clk);
    h_old = m_got && !m_lost && !m_rs && !m_ss;
    if (rst) begin
      m_l1 = 0; m_l2 = 0; m_got = 0; m_lost = 0; m_rs = 0; m_ss = 0;
      r_q1 = 0; r_q2 = 0; s_q1 = 0; s_q2 = 0; r_idle = 0; s_idle = 0; hc = 0;
    end else begin
      m_lost = m_lost || (m_got && !m_l2);
      m_got  = m_got || m_l2;
      m_l2 = m_l1; m_l1 = raw;
      m_rs = m_rs || (r_idle == ST);
      if (r_q2) r_idle = 0; else if (r_idle < ST) r_idle++;
      r_q2 = r_q1; r_q1 = rseen;
      m_ss = m_ss || (s_idle == ST);
      if (s_q2) s_idle = 0; else if (s_idle < ST) s_idle++;
      s_q2 = s_q1; s_q1 = sseen;
      if (!h_old) hc = 0; else if (hc < RD) hc++;
    end
    rseen = 0; sseen = 0;
    #2;
    if (!done) begin
      cmp("R1/R2", "lock_ok", lock_ok, m_got && !m_lost);
      cmp("R3", "ref_stopped", ref_stopped, m_rs);
      cmp("R4", "syn_stopped", syn_stopped, m_ss);
      cmp("R6", "healthy", healthy, m_got && !m_lost && !m_rs && !m_ss);
      cmp("R7/R8", "cascade_rst", cascade_rst, hc < RD);
    end
  end

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic do_reset();
    edges(1); rst = 1;
    edges(6); rst = 0;
  endtask

  initial begin
    look(6);
    cmp("R9", "healthy in reset", healthy, 1'b0);
    cmp("R9", "cascade_rst in reset", cascade_rst, 1'b1);
    cmp("R9", "lock_ok in reset", lock_ok, 1'b0);
    edges(0); rst = 0; raw = 1;
    look(3);
    cmp("R1", "lock_ok after sync", lock_ok, 1'b1);
    look(RD - 1);
    cmp("R7", "cascade_rst before delay", cascade_rst, 1'b1);
    look(1);
    cmp("R7", "cascade_rst released", cascade_rst, 1'b0);
    // R3 boundary: gap equal to the limit
    rhi = 5; rlo = 5;
    look(60);
    cmp("R3", "ref_stopped at gap=limit", ref_stopped, 1'b0);
    rlo = 6;
    look(40);
    cmp("R3", "ref_stopped at gap=limit+1", ref_stopped, 1'b1);
    cmp("R6", "healthy with raw high", healthy, 1'b0);
    cmp("R8", "cascade_rst after stop", cascade_rst, 1'b1);
    rhi = 2; rlo = 2;
    look(20);
    cmp("R5", "ref_stopped after resume", ref_stopped, 1'b1);
    do_reset();
    look(20);
    cmp("R9", "ref_stopped cleared", ref_stopped, 1'b0);
    cmp("R9", "healthy after reset", healthy, 1'b1);
    sen = 0;
    look(20);
    cmp("R4", "syn_stopped", syn_stopped, 1'b1);
    cmp("R4", "ref_stopped untouched", ref_stopped, 1'b0);
    sen = 1;
    look(10);
    cmp("R5", "syn_stopped after resume", syn_stopped, 1'b1);
    do_reset();
    look(20);
    cmp("R7", "cascade released again", cascade_rst, 1'b0);
    edges(0); raw = 0;
    edges(1); raw = 1;
    look(4);
    cmp("R2", "lock_ok after glitch", lock_ok, 1'b0);
    cmp("R8", "cascade_rst after glitch", cascade_rst, 1'b1);
    look(15);
    cmp("R2", "lock_ok stays low", lock_ok, 1'b0);
    do_reset();
    look(3 + RD);
    cmp("R7", "release after reacquire", cascade_rst, 1'b0);
    finish_run();
  end
endmodule